// File: doc/BRIEF.md
# Key Search Array Controller

This controller sits beside a bank of identical key-search cores inside one processing element of a systolic node chain. At the start of a search it hands every core a distinct starting key: the high part of each key is the node's identifier and the low part is the core's index. All cores then test one key each per round, in lockstep. At the end of every round without a match they all advance their key by the core count.

The controller runs the same round timing as the cores but does no keystream work itself. It keeps only one shared key base, never a per-core key. When the round ends, it samples the cores' found flags and picks the lowest-numbered core that reported a hit. It then rebuilds the winning key from the node identifier, its own key base and the winner's index. The key is packed into a 64-bit report word, offered to the downstream FIFO and held until accepted, and the cores are halted. If the node's share of the key space runs out with no hit, a not-found word is reported instead.

Top module: `key_search_ctrl`

## Requirements
- R1: After reset, core_run, core_load, core_step and rpt_valid are all low.
- R2: A start pulse while idle makes core_load high for exactly the following cycle, with core_run high from that cycle on. Core i's start key on core_key_init[i*KEY_W +: KEY_W] has the node identifier in its upper NODE_W bits and i in its lower KEY_W-NODE_W bits.
- R3: A round lasts TEST_CYCLES cycles, the first starting in the core_load cycle. core_step pulses for one cycle in the last cycle of every round that ends without a hit and is not the final round.
- R4: core_found is sampled only in the last cycle of a round. Flags raised in any other cycle have no effect.
- R5: When several eligible cores raise found in the same round end, the lowest core index wins.
- R6: The reported key is {node identifier, base + winner index}, where base is CORES times the number of completed rounds.
- R7: A hit report word has 24'h5A0001 in bits 63:40 and the rebuilt key in bits 39:0.
- R8: rpt_valid rises the cycle after the deciding round end. rpt_valid and rpt_data then stay unchanged until a cycle with rpt_ready high, after which rpt_valid is low.
- R9: While a report is pending and after it is accepted, core_run and core_step stay low.
- R10: When the final round (ceil(2^(KEY_W-NODE_W)/CORES) rounds in all) ends with no eligible hit, the report word is 24'h5A00FF in bits 63:40 with bits 39:0 zero.
- R11: In the final round, found flags from cores whose key would lie beyond the node's key space are ignored.
- R12: start is ignored while a search is running or a report is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a search (honoured only when idle) |
| node_id | input | NODE_W | Identifier of this node, captured at start |
| core_found | input | CORES | Found flag of each core |
| core_key_init | output | CORES*KEY_W | Start key of each core, core i in slice i |
| core_load | output | 1 | Cores load their start keys |
| core_run | output | 1 | Cores are running |
| core_step | output | 1 | Cores advance their key by CORES |
| rpt_valid | output | 1 | Report word is offered |
| rpt_data | output | 64 | Report word: tag in 63:40, key in 39:0 |
| rpt_ready | input | 1 | Downstream FIFO accepts the report word |

## Verification
Searches are run for several node identifiers with the hit placed in the first round, a middle round and the final round, so a wrong base increment or a wrong node field changes the reported key. Some found patterns have one bit set and others several, which separates a lowest-index pick from a highest-index or any-bit pick. In the final round, a flag set only on a core beyond the key space must give a not-found word, while a flag on an in-range core must give the top key of the space. All-ones noise placed mid-round, a start pulse during the run and during the report, and a report held back for several cycles show that flags, starts and backpressure outside their windows change nothing.

// File: rtl/ksc_pkg.sv
// Shared definitions for the key search array controller.
// Assumes nothing beyond IEEE 1800-2017.
package ksc_pkg;
    typedef enum logic [1:0] {
        KSC_IDLE   = 2'd0,
        KSC_RUN    = 2'd1,
        KSC_REPORT = 2'd2
    } ksc_state_t;

    localparam logic [23:0] KSC_TAG_HIT  = 24'h5A0001;
    localparam logic [23:0] KSC_TAG_MISS = 24'h5A00FF;
endpackage

// File: rtl/ksc_keymap.sv
// Builds the start key of every core: node identifier on top, core index
// below. Assumes CORES <= 2**(KEY_W-NODE_W).
module ksc_keymap #(
    parameter int KEY_W  = 40,
    parameter int NODE_W = 9,
    parameter int CORES  = 96
) (
    input  logic [NODE_W-1:0]      node,
    output logic [CORES*KEY_W-1:0] keys
);
    localparam int LOW_W = KEY_W - NODE_W;

    // one slice per core: fixed node field, index field
    for (genvar i = 0; i < CORES; i++) begin : g_core
        assign keys[i*KEY_W +: KEY_W] = {node, LOW_W'(i)};
    end
endmodule

// File: rtl/ksc_pick.sv
// Picks the lowest-numbered eligible core that raised found. A core is
// eligible when base + index still lies inside the node's key space.
// Assumes base < 2**LOW_W.
module ksc_pick #(
    parameter int LOW_W = 31,
    parameter int CORES = 96,
    localparam int IDX_W = (CORES > 1) ? $clog2(CORES) : 1
) (
    input  logic [LOW_W-1:0] base,
    input  logic [CORES-1:0] found,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    logic [CORES-1:0] elig;

    // mask off cores whose key would run past the end of the space (R11)
    for (genvar i = 0; i < CORES; i++) begin : g_elig
        logic [LOW_W:0] sum;
        assign sum     = {1'b0, base} + (LOW_W+1)'(i);
        assign elig[i] = found[i] & ~sum[LOW_W];
    end

    // priority encoder, lowest index wins
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = CORES - 1; i >= 0; i--) begin
            if (elig[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    // R5: the winner raised found and no lower eligible core did
    always_comb begin
        if (hit) begin
            winner_found_chk: assert (found[idx]);
            for (int i = 0; i < CORES; i++) begin
                if (IDX_W'(i) < idx) begin
                    lowest_wins_chk: assert (!elig[i]);
                end
            end
        end
    end
endmodule

// File: rtl/ksc_seq.sv
// Lockstep round sequencer: a phase counter over one key test and the
// shared key base that grows by CORES at each advancing round end.
// Assumes TEST_CYCLES >= 2 and CORES <= 2**LOW_W.
module ksc_seq #(
    parameter int LOW_W       = 31,
    parameter int CORES       = 96,
    parameter int TEST_CYCLES = 816,
    localparam int PH_W = $clog2(TEST_CYCLES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             adv,
    output logic             phase_last,
    output logic             last_round,
    output logic [LOW_W-1:0] base
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(TEST_CYCLES - 1);

    logic [PH_W-1:0] phase;
    logic [LOW_W:0]  base_nx;

    assign phase_last = (phase == PH_LAST);
    assign base_nx    = {1'b0, base} + (LOW_W+1)'(CORES);
    assign last_round = base_nx[LOW_W];

    // phase counter over one key test
    always_ff @(posedge clk) begin
        if (!rst_n || clr)   phase <= '0;
        else if (run)        phase <= phase_last ? '0 : phase + 1'b1;
    end

    // shared key base, advanced at round end
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                 base <= '0;
        else if (run && phase_last && adv) base <= base_nx[LOW_W-1:0];
    end

    // R3: rounds are at least two cycles, so advances never come back to back
    adv_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && phase_last && adv) |=> !(run && phase_last));

    // R10: the base never advances past the final round
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && phase_last && adv) |-> !last_round);
endmodule

// File: rtl/key_search_ctrl.sv
// Key search array controller: hands out start keys, runs the round
// sequence in lockstep with the cores, picks the winning core at each
// round end, rebuilds its key and reports it as one 64-bit word held until
// accepted. Assumes the cores hold found valid in the last cycle of a round.
module key_search_ctrl #(
    parameter int KEY_W       = 40,
    parameter int NODE_W      = 9,
    parameter int CORES       = 96,
    parameter int TEST_CYCLES = 816,
    parameter int RPT_W       = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [NODE_W-1:0]      node_id,
    input  logic [CORES-1:0]       core_found,
    output logic [CORES*KEY_W-1:0] core_key_init,
    output logic                   core_load,
    output logic                   core_run,
    output logic                   core_step,
    output logic                   rpt_valid,
    output logic [RPT_W-1:0]       rpt_data,
    input  logic                   rpt_ready
);
    import ksc_pkg::*;

    localparam int LOW_W = KEY_W - NODE_W;
    localparam int IDX_W = (CORES > 1) ? $clog2(CORES) : 1;
    localparam int TAG_W = RPT_W - KEY_W;

    ksc_state_t        state;
    logic [NODE_W-1:0] node_q;
    logic              load_q;
    logic              phase_last, last_round, hit, adv, launch;
    logic [LOW_W-1:0]  base;
    logic [IDX_W-1:0]  idx;
    logic [LOW_W-1:0]  key_low;

    assign launch  = (state == KSC_IDLE) && start;
    assign adv     = !hit && !last_round;
    assign key_low = base + LOW_W'(idx);

    ksc_keymap #(.KEY_W(KEY_W), .NODE_W(NODE_W), .CORES(CORES)) u_keymap (
        .node (node_q),
        .keys (core_key_init)
    );

    ksc_seq #(.LOW_W(LOW_W), .CORES(CORES), .TEST_CYCLES(TEST_CYCLES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (launch),
        .run        (core_run),
        .adv        (adv),
        .phase_last (phase_last),
        .last_round (last_round),
        .base       (base)
    );

    ksc_pick #(.LOW_W(LOW_W), .CORES(CORES)) u_pick (
        .base  (base),
        .found (core_found),
        .hit   (hit),
        .idx   (idx)
    );

    // control state: idle, running rounds, holding a report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= KSC_IDLE;
        end else begin
            case (state)
                KSC_IDLE:   if (start) state <= KSC_RUN;
                KSC_RUN:    if (phase_last && (hit || last_round)) state <= KSC_REPORT;
                KSC_REPORT: if (rpt_ready) state <= KSC_IDLE;
                default:    state <= KSC_IDLE;
            endcase
        end
    end

    // capture node identifier and raise the one-cycle load at launch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            node_q <= '0;
            load_q <= 1'b0;
        end else begin
            load_q <= launch;
            if (launch) node_q <= node_id;
        end
    end

    // build the report word at the deciding round end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rpt_data <= '0;
        end else if (core_run && phase_last) begin
            if (hit)             rpt_data <= {TAG_W'(KSC_TAG_HIT), node_q, key_low};
            else if (last_round) rpt_data <= {TAG_W'(KSC_TAG_MISS), KEY_W'(0)};
        end
    end

    assign core_run  = (state == KSC_RUN);
    assign core_load = load_q;
    assign core_step = core_run && phase_last && adv;
    assign rpt_valid = (state == KSC_REPORT);

    // R8
    rpt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && !rpt_ready) |=> (rpt_valid && $stable(rpt_data)));

    // R9
    halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |-> (!core_run && !core_step));

    // R2
    load_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_load |=> !core_load);

    // R12
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && !rpt_ready) |=> !core_load);
endmodule

// File: tb/key_search_ctrl_tb.sv
// Bench: a vector table of whole searches walked by one loop, then
// directed reset checks. Small key space: 6 low bits, 5 cores, 4-cycle rounds.
module key_search_ctrl_tb;
    localparam int KEY_W = 40;
    localparam int NODE_W = 34;
    localparam int CORES = 5;
    localparam int TC = 4;
    localparam int LOW_W = KEY_W - NODE_W;
    localparam int LAST_R = 12; // ceil(64/5)-1

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [NODE_W-1:0] node_id = '0;
    logic [CORES-1:0] core_found = '0;
    logic [CORES*KEY_W-1:0] core_key_init;
    logic core_load, core_run, core_step, rpt_valid, rpt_ready = 1'b0;
    logic [63:0] rpt_data;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    key_search_ctrl #(.KEY_W(KEY_W), .NODE_W(NODE_W), .CORES(CORES),
                      .TEST_CYCLES(TC), .RPT_W(64)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .node_id(node_id),
        .core_found(core_found), .core_key_init(core_key_init),
        .core_load(core_load), .core_run(core_run), .core_step(core_step),
        .rpt_valid(rpt_valid), .rpt_data(rpt_data), .rpt_ready(rpt_ready)
    );

    typedef struct packed {
        logic [NODE_W-1:0] node;
        logic [7:0]        tgt;
        logic [CORES-1:0]  mask;
        logic              hit;
        logic [LOW_W-1:0]  low;
        logic [3:0]        wait_n;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{34'h0_0000_0001, 8'd0,  5'b00100, 1'b1, 6'd2,  4'd0},
        '{34'h3_0000_0001, 8'd3,  5'b10010, 1'b1, 6'd16, 4'd3},
        '{34'h0_0DEA_DBEE, 8'd12, 5'b10000, 1'b0, 6'd0,  4'd1},
        '{34'h2_5555_AAAA, 8'd12, 5'b11000, 1'b1, 6'd63, 4'd2},
        '{34'h1_2345_6789, 8'd7,  5'b11111, 1'b1, 6'd35, 4'd0},
        '{34'h3_FFFF_FFFF, 8'd99, 5'b00000, 1'b0, 6'd0,  4'd1}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_case(input vec_t v, input int n);
        logic [63:0] exp_word;
        string req;
        int steps = 0;
        bit stop = 0;
        if (v.hit) exp_word = {24'h5A0001, v.node, v.low};
        else       exp_word = {24'h5A00FF, 40'h0};
        req = (v.tgt == LAST_R) ? "R11 report" : (v.hit ? "R6 R7 report" : "R10 report");
        @(negedge clk); start = 1'b1; node_id = v.node;
        @(negedge clk); start = 1'b0; node_id = ~v.node;
        #1;
        check(core_load && core_run, "R2 load/run", {62'h0, core_load, core_run}, 64'h3);
        check(core_key_init[0 +: KEY_W] == {v.node, 6'd0}, "R2 key core0",
              64'(core_key_init[0 +: KEY_W]), 64'({v.node, 6'd0}));
        check(core_key_init[(CORES-1)*KEY_W +: KEY_W] == {v.node, 6'd4}, "R2 key core4",
              64'(core_key_init[(CORES-1)*KEY_W +: KEY_W]), 64'({v.node, 6'd4}));
        for (int r = 0; r <= LAST_R && !stop; r++) begin
            for (int p = 0; p < TC; p++) begin
                bit exp_step;
                core_found = '0;
                if (p == 1) core_found = '1;                 // mid-round noise, R4
                if (p == TC-1 && r == v.tgt) core_found = v.mask;
                start = (n == 1 && r == 1 && p == 2);        // R12 start while running
                #1;
                exp_step = (p == TC-1) && !(r == v.tgt && v.hit) && (r != LAST_R);
                check(core_step == exp_step, "R3 R4 step", 64'(core_step), 64'(exp_step));
                if (r == 0 && p == 1)
                    check(!core_load, "R2 load one cycle", 64'(core_load), 64'h0);
                if (core_step) steps++;
                if (p == TC-1 && ((r == v.tgt && v.hit) || r == LAST_R)) stop = 1;
                @(negedge clk);
            end
        end
        core_found = '0;
        start = 1'b0;
        check(steps == (v.hit ? int'(v.tgt) : LAST_R), "R3 step count", 64'(steps),
              64'(v.hit ? int'(v.tgt) : LAST_R));
        for (int k = 0; k <= int'(v.wait_n); k++) begin
            rpt_ready = (k == int'(v.wait_n));
            start = (k == 0 && v.wait_n != 0);               // R12 start while reporting
            #1;
            check(rpt_valid, "R8 valid held", 64'(rpt_valid), 64'h1);
            check(rpt_data == exp_word, req, rpt_data, exp_word);
            check(!core_run && !core_step, "R9 halted", {62'h0, core_run, core_step}, 64'h0);
            @(negedge clk);
        end
        rpt_ready = 1'b0;
        start = 1'b0;
        #1;
        check(!rpt_valid, "R8 released", 64'(rpt_valid), 64'h0);
        check(!core_run && !core_load, "R9 R12 stays halted",
              {62'h0, core_run, core_load}, 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        check(!core_run && !core_load && !core_step && !rpt_valid, "R1 reset",
              {60'h0, core_run, core_load, core_step, rpt_valid}, 64'h0);
        @(negedge clk); rst_n = 1'b1;
        for (int n = 0; n < 6; n++) run_case(VECS[n], n);

        // R1: reset in the middle of a search
        @(negedge clk); start = 1'b1; node_id = 34'h5;
        @(negedge clk); start = 1'b0;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); #1;
        check(!core_run && !core_load && !core_step && !rpt_valid, "R1 mid reset",
              {60'h0, core_run, core_load, core_step, rpt_valid}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(!core_run, "R1 idle after reset", 64'(core_run), 64'h0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule